// File: doc/BRIEF.md
# Buffered Left/Center-Aligned PWM Channel

This block is one 8-bit pulse-width modulation channel. A free-running counter advances on a channel clock-enable pulse. It is compared against an active period value and an active duty value to produce a single output waveform. Software sets the period and duty through a small register bus. While the channel runs, each write lands in a shadow copy, and the shadow is moved into the active copy only at a period boundary, so a running waveform never sees a half-updated setting. A write to the counter address restarts the count and forces the shadows into use at once.

Two counting shapes are available. In edge mode the counter climbs to the period value and starts again from zero. In symmetric mode it climbs to the period value, turns, and descends back to zero, which doubles the output period and centres the pulse. A polarity input selects the output level that holds at the start of each cycle. Two test inputs can stop a counter write from clearing the count, and can stop the period match from acting.

Top module: `pwm_buffered_chan`

## Requirements
- R1: After reset the count, the period shadow and active value, and the duty shadow and active value are all 0x00, and the counter direction is upward.
- R2: The read data is selected by `addr` without side effects: 0 returns the live count, 1 the period shadow, 2 the duty shadow, 3 returns 0x00; reading any number of times does not alter counting or the output.
- R3: The count changes on a clock edge only when `enable` and `tick` are both high, or when the counter address is written.
- R4: A bus write to address 0 clears the count to 0x00, sets the direction upward, and copies both shadows into the active registers in that same edge; it takes precedence over counting.
- R5: In edge mode (`center`=0), a tick while the count equals the active period sets the count to 0x00 and loads both shadows into the active registers, so the output repeats every period+1 ticks.
- R6: In symmetric mode (`center`=1), the count rises to the active period, holds there for one tick while turning downward, falls to 0x00, holds there for one tick while turning upward and loading both shadows, so the output repeats every 2×(period+1) ticks.
- R7: `pwm_out` equals `polarity` while the count is below the active duty value and the inverse of `polarity` otherwise.
- R8: A period or duty write (address 1 or 2) while `enable` is high changes only the shadow, which reads back at once; the active value changes only at the next period boundary or counter write.
- R9: A period or duty write while `enable` is low updates both the shadow and the active value in the same edge.
- R10: With `tst_keep` high, a counter write leaves the count and direction unchanged but still loads both shadows into the active registers.
- R11: With `tst_nomatch` high, a period match does nothing: in edge mode the count keeps incrementing, wrapping from 0xFF to 0x00 without a reload; in symmetric mode no turn occurs at the top.
- R12: When `enable` returns high, counting resumes from the value held while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run enable |
| tick | input | 1 | Channel clock-enable pulse |
| center | input | 1 | 1 selects symmetric up/down counting |
| polarity | input | 1 | Output level at the start of each cycle |
| tst_keep | input | 1 | Test: counter write does not clear the count |
| tst_nomatch | input | 1 | Test: period match is ignored |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 2 | Register select (0 count, 1 period, 2 duty) |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data for `addr` |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions take one bus access per cycle as given, so a counter write can never coincide with a period or duty write, and they assume the mode and test inputs are stable around each edge they judge. The stimulus changes these inputs only between clock edges, issues writes one at a time through a single task, and switches modes only after a counter write has put the count in a known state. The reload check relies on the shadow being untouched in the writing cycle, which the single-address bus guarantees.

// File: rtl/pwm_buffered_chan.sv
module pwm_buffered_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         tick,
  input  logic         center,
  input  logic         polarity,
  input  logic         tst_keep,
  input  logic         tst_nomatch,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         pwm_out
);

  localparam logic [1:0] A_CNT  = 2'd0;
  localparam logic [1:0] A_PER  = 2'd1;
  localparam logic [1:0] A_DUTY = 2'd2;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt, per_act, per_buf, duty_act, duty_buf;
  logic         dir_down;

  wire cnt_wr  = wr_en && (addr == A_CNT);
  wire per_wr  = wr_en && (addr == A_PER);
  wire duty_wr = wr_en && (addr == A_DUTY);
  wire step    = enable && tick;

  wire at_top   = (cnt == per_act);
  wire at_bot   = (cnt == '0);
  wire left_end = !center && at_top && !tst_nomatch;
  wire ctr_turn = center && !dir_down && at_top && !tst_nomatch;
  wire ctr_end  = center && dir_down && at_bot;
  wire reload   = cnt_wr || (step && (left_end || ctr_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
    end else begin
      if (per_wr)  per_buf  <= wdata;
      if (duty_wr) duty_buf <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      if (per_wr && !enable)       per_act <= wdata;
      else if (reload)             per_act <= per_buf;
      if (duty_wr && !enable)      duty_act <= wdata;
      else if (reload)             duty_act <= duty_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (cnt_wr) begin
      if (!tst_keep) begin
        cnt      <= '0;
        dir_down <= 1'b0;
      end
    end else if (step) begin
      if (!center) begin
        dir_down <= 1'b0;
        cnt      <= left_end ? '0 : cnt + ONE;
      end else if (ctr_turn) begin
        dir_down <= 1'b1;
      end else if (ctr_end) begin
        dir_down <= 1'b0;
      end else begin
        cnt <= dir_down ? cnt - ONE : cnt + ONE;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CNT:   rdata = cnt;
      A_PER:   rdata = per_buf;
      A_DUTY:  rdata = duty_buf;
      default: rdata = '0;
    endcase
  end

  assign pwm_out = (cnt < duty_act) ? polarity : !polarity;

endmodule

module pwm_chan_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         tick,
  input logic         center,
  input logic         tst_keep,
  input logic         tst_nomatch,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per_act,
  input logic [W-1:0] per_buf,
  input logic         dir_down
);

  wire c_wr   = wr_en && (addr == 2'd0);
  wire c_step = enable && tick;

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_step && !c_wr) |=> $stable(cnt));

  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && !tst_keep) |=> (cnt == '0) && !dir_down);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> (per_act == $past(per_buf)));

  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && tst_keep) |=> $stable(cnt));

  assert_left_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_step && !c_wr && !center && !tst_nomatch && cnt == per_act) |=> (cnt == '0));

  assert_center_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_step && !c_wr && center && !tst_nomatch && !dir_down && cnt == per_act)
      |=> (dir_down && $stable(cnt)));

  assert_nomatch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (c_step && !c_wr && !center && tst_nomatch) |=> (cnt == W'($past(cnt) + 1'b1)));

endmodule

bind pwm_buffered_chan pwm_chan_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .center(center),
  .tst_keep(tst_keep), .tst_nomatch(tst_nomatch), .wr_en(wr_en), .addr(addr),
  .cnt(cnt), .per_act(per_act), .per_buf(per_buf), .dir_down(dir_down)
);

// File: tb/pwm_buffered_chan_tb.sv
`timescale 1ns/1ps
module pwm_buffered_chan_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, tick = 1'b0, center = 1'b0, polarity = 1'b1;
  logic       tst_keep = 1'b0, tst_nomatch = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pwm_out;

  always #5 clk = ~clk;

  pwm_buffered_chan u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .center(center),
    .polarity(polarity), .tst_keep(tst_keep), .tst_nomatch(tst_nomatch),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  typedef struct { string req; logic [7:0] rd; logic po; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  logic [7:0] m_cnt = 0, m_pact = 0, m_dact = 0, m_pbuf = 0, m_dbuf = 0;
  logic       m_down = 0;

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_pbuf;
      2'd2: return m_dbuf;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_edge();
    logic cw, pw, dw, st, lend, cturn, cend, rl;
    logic [7:0] n_cnt, n_pact, n_dact;
    logic n_down;
    cw = wr_en && addr == 2'd0;
    pw = wr_en && addr == 2'd1;
    dw = wr_en && addr == 2'd2;
    st = enable && tick;
    lend  = !center && m_cnt == m_pact && !tst_nomatch;
    cturn = center && !m_down && m_cnt == m_pact && !tst_nomatch;
    cend  = center && m_down && m_cnt == 8'd0;
    rl = cw || (st && (lend || cend));
    n_pact = (pw && !enable) ? wdata : (rl ? m_pbuf : m_pact);
    n_dact = (dw && !enable) ? wdata : (rl ? m_dbuf : m_dact);
    n_cnt = m_cnt; n_down = m_down;
    if (cw) begin
      if (!tst_keep) begin n_cnt = 0; n_down = 0; end
    end else if (st) begin
      if (!center) begin n_down = 0; n_cnt = lend ? 8'd0 : m_cnt + 8'd1; end
      else if (cturn) n_down = 1;
      else if (cend) n_down = 0;
      else n_cnt = m_down ? m_cnt - 8'd1 : m_cnt + 8'd1;
    end
    if (pw) m_pbuf = wdata;
    if (dw) m_dbuf = wdata;
    m_cnt = n_cnt; m_down = n_down; m_pact = n_pact; m_dact = n_dact;
  endtask

  task automatic push_exp();
    exp_t e;
    e.req = cur_req;
    e.rd  = m_read(addr);
    e.po  = (m_cnt < m_dact) ? polarity : !polarity;
    q.push_back(e);
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      push_exp();
      #2;
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    run(1);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic chk(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (rdata !== e.rd || pwm_out !== e.po) begin
        n_fail++;
        $display("FAIL %s rdata=%h exp=%h out=%b exp=%b", e.req, rdata, e.rd, pwm_out, e.po);
      end
    end
  end

  // cycles between two entries into the polarity level
  task automatic measure(string req, int exp_len);
    logic prev;
    int first, n;
    first = -1; n = 0; prev = pwm_out;
    for (int i = 0; i < 80; i++) begin
      run(1);
      if (pwm_out == polarity && prev != polarity) begin
        if (first < 0) first = i;
        else if (n == 0) n = i - first;
      end
      prev = pwm_out;
    end
    chk(req, n, exp_len);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; addr = 2'd0; run(1);
    addr = 2'd1; run(1);
    addr = 2'd2; run(1);
    cur_req = "R2"; addr = 2'd3; run(1);
    addr = 2'd0;

    cur_req = "R9";
    bus_wr(2'd1, 8'd4);
    bus_wr(2'd2, 8'd2);
    addr = 2'd1; run(1); addr = 2'd0;

    cur_req = "R5"; enable = 1; tick = 1; polarity = 1;
    run(12);
    measure("R5", 5);
    cur_req = "R7"; run(6);

    cur_req = "R3";
    for (int i = 0; i < 10; i++) begin tick = i[0]; run(1); end
    tick = 1; enable = 0; run(5);
    cur_req = "R12"; enable = 1; run(4);

    cur_req = "R8"; bus_wr(2'd1, 8'd7);
    addr = 2'd1; run(2); addr = 2'd0;
    run(20);
    measure("R8", 8);

    cur_req = "R4"; run(3); bus_wr(2'd0, 8'hAA); run(3);
    cur_req = "R2"; addr = 2'd0; run(4);

    cur_req = "R6";
    bus_wr(2'd1, 8'd3); bus_wr(2'd2, 8'd2);
    polarity = 0; center = 1; bus_wr(2'd0, 8'd0);
    run(20);
    measure("R6", 8);

    cur_req = "R10"; tst_keep = 1;
    bus_wr(2'd1, 8'd5); run(2);
    bus_wr(2'd0, 8'd0); run(14);
    tst_keep = 0;

    cur_req = "R11"; center = 0; bus_wr(2'd0, 8'd0);
    tst_nomatch = 1; run(270);
    center = 1; run(20);
    tst_nomatch = 0; center = 0; bus_wr(2'd0, 8'd0); run(8);

    @(negedge clk); #3;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule